// File: doc/BRIEF.md
# PHY Power-Up Sequencer

This block walks an analog storage-interface PHY through its power transitions. A power-off request parks the PHY by dropping both the power-down-bar line and the DLL enable, then reports completion. A power-on request does the same first. It then holds power-down-bar low for a settle interval and raises it. Next it waits for the calibration pad to report completion. After that it applies a frequency band chosen from the measured card-clock rate, enables the DLL and waits for the DLL to lock.

Both waits are bounded. The calibration wait is short and counted in microseconds. The lock wait is long and counted in milliseconds. Either one running out ends the sequence with a one-cycle error pulse. When the measured card-clock rate is zero, the DLL is enabled but lock is not awaited, because it can never lock without a clock. All intervals are counted in system-clock cycles derived from a clock-frequency parameter. A warning flag marks card-clock rates that sit too far from their band centre or above the top band.

Top module: `phy_pwr_seq`

## Requirements
- R1: A request accepted while idle drives `pwr_dn_b` and `dll_en` low on the next clock edge. A power-off request also pulses `seq_done` on that same edge and ends the sequence.
- R2: `card_rate_hz` is in hertz and is sampled when a power-on request is accepted. `freq_band` takes code 1 for a nonzero rate below 75,000,000, code 2 for a rate from 75,000,000 up to 124,999,999, code 3 for a rate from 125,000,000 up to 174,999,999, and code 0 for 175,000,000 and above or for zero. Its reset value is 0.
- R3: When a power-on request is accepted, `rate_warn` is set to the result of the following test: the rate is above 50,000,000 and differs from its band centre (50, 100, 150 or 200 MHz) by more than 15,000,000, or the rate is above 200,000,000. The flag is cleared by an accepted power-off request and is held otherwise.
- R4: `pwr_dn_b` stays low for SETTLE_US × ceil(SYS_CLK_HZ/1e6) cycles after a power-on request is accepted, then rises.
- R5: If `cal_done` is not sampled high within CAL_TMO_US × ceil(SYS_CLK_HZ/1e6) cycles after `pwr_dn_b` rises, `seq_err` pulses at the end of that window. `dll_en` stays low in that case.
- R6: The edge after `cal_done` is sampled high, `freq_band` takes the band. One edge later `dll_en` rises. `freq_band` does not change while `dll_en` is high.
- R7: With a sampled rate of zero, `seq_done` pulses on the same edge that raises `dll_en`.
- R8: With a nonzero rate, `seq_done` pulses on the edge after `dll_ready` is sampled high. If `dll_ready` is not sampled high within DLL_TMO_MS × 1000 × ceil(SYS_CLK_HZ/1e6) cycles after `dll_en` rises, `seq_err` pulses instead.
- R9: `seq_done` and `seq_err` are single-cycle pulses and are never high together.
- R10: Requests are ignored while a sequence is in progress. If both requests arrive together while idle, the power-off request wins.
- R11: `dll_en` is only ever high while `pwr_dn_b` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| on_req | input | 1 | Power-on request, sampled while idle |
| off_req | input | 1 | Power-off request, sampled while idle |
| card_rate_hz | input | RATE_W | Measured card-clock rate in Hz |
| cal_done | input | 1 | Calibration complete status |
| dll_ready | input | 1 | DLL lock status |
| pwr_dn_b | output | 1 | PHY power-down-bar (high = powered) |
| dll_en | output | 1 | DLL enable |
| freq_band | output | 2 | DLL frequency band code |
| seq_done | output | 1 | Sequence finished successfully (pulse) |
| seq_err | output | 1 | Sequence timed out (pulse) |
| rate_warn | output | 1 | Card-clock rate out of tolerance |

## Verification
The bench builds the block with a 1 MHz system-clock parameter, so each microsecond equals one cycle. With that setting the settle interval is 3 cycles and the calibration window is 50 cycles. The lock timeout is shortened to 4 ms, which is 4000 cycles. At these values both timeouts fire well within the run, and calibration latencies just inside and just outside the window can be driven directly. Rates are drawn at random and also set at every band edge and warning edge, so each band code and each side of the 15 MHz tolerance is exercised.

// File: rtl/phy_seq_pkg.sv
// Package: shared types for the PHY power sequencer.
// Assumes: band codes are decoded downstream by the PHY, so their values are fixed.
package phy_seq_pkg;

    typedef enum logic [1:0] {
        BAND_200 = 2'd0,
        BAND_50  = 2'd1,
        BAND_100 = 2'd2,
        BAND_150 = 2'd3
    } band_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_CAL,
        ST_DLL_ON,
        ST_LOCK
    } seq_state_e;

endpackage

// File: rtl/phy_rate_band.sv
// Module: classifies a card-clock rate into a DLL band and flags out-of-tolerance rates.
// Assumes: the rate is in Hz and RATE_W is at least 28 so that 260 MHz is representable.
module phy_rate_band
    import phy_seq_pkg::*;
#(
    parameter int unsigned RATE_W = 32
) (
    input  logic [RATE_W-1:0] rate,
    output band_e             band,
    output logic              warn
);
    localparam logic [RATE_W-1:0] F15  = RATE_W'(15_000_000);
    localparam logic [RATE_W-1:0] F50  = RATE_W'(50_000_000);
    localparam logic [RATE_W-1:0] F75  = RATE_W'(75_000_000);
    localparam logic [RATE_W-1:0] F100 = RATE_W'(100_000_000);
    localparam logic [RATE_W-1:0] F125 = RATE_W'(125_000_000);
    localparam logic [RATE_W-1:0] F150 = RATE_W'(150_000_000);
    localparam logic [RATE_W-1:0] F175 = RATE_W'(175_000_000);
    localparam logic [RATE_W-1:0] F200 = RATE_W'(200_000_000);

    logic [RATE_W-1:0] centre;
    logic [RATE_W-1:0] diff;

    // Pick band and centre frequency from the rate thresholds.
    always_comb begin
        if (rate == '0) begin
            band   = BAND_200;
            centre = F200;
        end else if (rate < F75) begin
            band   = BAND_50;
            centre = F50;
        end else if (rate < F125) begin
            band   = BAND_100;
            centre = F100;
        end else if (rate < F175) begin
            band   = BAND_150;
            centre = F150;
        end else begin
            band   = BAND_200;
            centre = F200;
        end
    end

    // Distance from band centre and the resulting tolerance warning.
    always_comb begin
        diff = (rate > centre) ? (rate - centre) : (centre - rate);
        warn = ((rate > F50) && (diff > F15)) || (rate > F200);
    end

endmodule

// File: rtl/phy_wait_timer.sv
// Module: cycle counter shared by all timed waits of the sequencer.
// Assumes: the owner pulses clear on every state change; hit marks the cycle
// whose count equals the selected last value.
module phy_wait_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] last,
    output logic         hit
);
    logic [W-1:0] cnt_q;

    // Count cycles since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign hit = (cnt_q == last);

endmodule

// File: rtl/phy_pwr_seq.sv
// Module: top of the PHY power sequencer. Handles power-off, settle, calibration
// wait, band apply, DLL enable and lock wait, with bounded waits.
// Assumes: status inputs are already synchronous to clk; requests are only
// honoured while idle.
module phy_pwr_seq
    import phy_seq_pkg::*;
#(
    parameter int unsigned SYS_CLK_HZ = 100_000_000,
    parameter int unsigned SETTLE_US  = 3,
    parameter int unsigned CAL_TMO_US = 50,
    parameter int unsigned DLL_TMO_MS = 50,
    parameter int unsigned RATE_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              on_req,
    input  logic              off_req,
    input  logic [RATE_W-1:0] card_rate_hz,
    input  logic              cal_done,
    input  logic              dll_ready,
    output logic              pwr_dn_b,
    output logic              dll_en,
    output logic [1:0]        freq_band,
    output logic              seq_done,
    output logic              seq_err,
    output logic              rate_warn
);
    localparam int unsigned CYC_PER_US = (SYS_CLK_HZ + 999_999) / 1_000_000;
    localparam int unsigned SETTLE_CYC = (CYC_PER_US * SETTLE_US  > 0) ? CYC_PER_US * SETTLE_US  : 1;
    localparam int unsigned CAL_CYC    = (CYC_PER_US * CAL_TMO_US > 0) ? CYC_PER_US * CAL_TMO_US : 1;
    localparam int unsigned DLL_CYC    = (CYC_PER_US * 1000 * DLL_TMO_MS > 0) ?
                                         CYC_PER_US * 1000 * DLL_TMO_MS : 1;
    localparam int unsigned TMR_W      = $clog2(SETTLE_CYC + CAL_CYC + DLL_CYC + 1);

    seq_state_e state_q, state_d;
    logic       pdb_q, pdb_d;
    logic       den_q, den_d;
    band_e      freq_q, freq_d;
    band_e      band_q, band_d;
    logic       zero_q, zero_d;
    logic       warn_q, warn_d;
    logic       done_q, done_d;
    logic       err_q, err_d;

    band_e              band_c;
    logic               warn_c;
    logic [TMR_W-1:0]   tmr_last;
    logic               tmr_hit;
    logic               tmr_clear;

    phy_rate_band #(.RATE_W(RATE_W)) u_band (
        .rate (card_rate_hz),
        .band (band_c),
        .warn (warn_c)
    );

    // Select the terminal count for the wait of the current state.
    always_comb begin
        case (state_q)
            ST_SETTLE: tmr_last = TMR_W'(SETTLE_CYC - 1);
            ST_CAL:    tmr_last = TMR_W'(CAL_CYC - 1);
            default:   tmr_last = TMR_W'(DLL_CYC - 1);
        endcase
    end

    assign tmr_clear = (state_d != state_q);

    phy_wait_timer #(.W(TMR_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .last  (tmr_last),
        .hit   (tmr_hit)
    );

    // Next-state and output decisions of the sequence.
    always_comb begin
        state_d = state_q;
        pdb_d   = pdb_q;
        den_d   = den_q;
        freq_d  = freq_q;
        band_d  = band_q;
        zero_d  = zero_q;
        warn_d  = warn_q;
        done_d  = 1'b0;
        err_d   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (off_req) begin
                    pdb_d  = 1'b0;
                    den_d  = 1'b0;
                    warn_d = 1'b0;
                    done_d = 1'b1;
                end else if (on_req) begin
                    pdb_d   = 1'b0;
                    den_d   = 1'b0;
                    band_d  = band_c;
                    zero_d  = (card_rate_hz == '0);
                    warn_d  = warn_c;
                    state_d = ST_SETTLE;
                end
            end
            ST_SETTLE: begin
                if (tmr_hit) begin
                    pdb_d   = 1'b1;
                    state_d = ST_CAL;
                end
            end
            ST_CAL: begin
                if (cal_done) begin
                    freq_d  = band_q;
                    state_d = ST_DLL_ON;
                end else if (tmr_hit) begin
                    err_d   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_DLL_ON: begin
                den_d = 1'b1;
                if (zero_q) begin
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (dll_ready) begin
                    done_d  = 1'b1;
                    state_d = ST_IDLE;
                end else if (tmr_hit) begin
                    err_d   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pdb_q   <= 1'b0;
            den_q   <= 1'b0;
            freq_q  <= BAND_200;
            band_q  <= BAND_200;
            zero_q  <= 1'b0;
            warn_q  <= 1'b0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            pdb_q   <= pdb_d;
            den_q   <= den_d;
            freq_q  <= freq_d;
            band_q  <= band_d;
            zero_q  <= zero_d;
            warn_q  <= warn_d;
            done_q  <= done_d;
            err_q   <= err_d;
        end
    end

    assign pwr_dn_b  = pdb_q;
    assign dll_en    = den_q;
    assign freq_band = freq_q;
    assign seq_done  = done_q;
    assign seq_err   = err_q;
    assign rate_warn = warn_q;

endmodule

// File: rtl/phy_pwr_seq_chk.sv
// Module: property checker for the PHY power sequencer, bound to the top.
// Assumes: observes only the top-level outputs plus its own settle counter.
module phy_pwr_seq_chk #(
    parameter int unsigned SETTLE_CYC = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_dn_b,
    input logic       dll_en,
    input logic [1:0] freq_band,
    input logic       seq_done,
    input logic       seq_err
);
    int unsigned low_run;

    // Count consecutive sampled cycles with power-down-bar low (saturating).
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_dn_b) begin
            low_run <= 0;
        end else if (low_run < SETTLE_CYC) begin
            low_run <= low_run + 1;
        end
    end

    AST_SETTLE_BEFORE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_dn_b) |-> (low_run >= SETTLE_CYC)); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !seq_done); // R9
    AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> !seq_err); // R9
    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(seq_done && seq_err)); // R9
    AST_DLL_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
        dll_en |-> pwr_dn_b); // R11
    AST_BAND_HELD_WITH_DLL: assert property (@(posedge clk) disable iff (!rst_n)
        (dll_en && $past(dll_en)) |-> $stable(freq_band)); // R6

endmodule

bind phy_pwr_seq phy_pwr_seq_chk #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn_b  (pwr_dn_b),
    .dll_en    (dll_en),
    .freq_band (freq_band),
    .seq_done  (seq_done),
    .seq_err   (seq_err)
);

// File: tb/phy_pwr_seq_tb.sv
// Bench: directed corners plus seeded random power-on runs against a bench model.
module phy_pwr_seq_tb;
    localparam int unsigned CLK_HZ = 1_000_000;
    localparam int S    = 3;
    localparam int CAL  = 50;
    localparam int DLL  = 4000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        on_req = 1'b0;
    logic        off_req = 1'b0;
    logic [31:0] card_rate_hz = '0;
    logic        cal_done = 1'b0;
    logic        dll_ready = 1'b0;
    logic        pwr_dn_b, dll_en, seq_done, seq_err, rate_warn;
    logic [1:0]  freq_band;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    phy_pwr_seq #(
        .SYS_CLK_HZ (CLK_HZ),
        .SETTLE_US  (3),
        .CAL_TMO_US (50),
        .DLL_TMO_MS (4),
        .RATE_W     (32)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .on_req       (on_req),
        .off_req      (off_req),
        .card_rate_hz (card_rate_hz),
        .cal_done     (cal_done),
        .dll_ready    (dll_ready),
        .pwr_dn_b     (pwr_dn_b),
        .dll_en       (dll_en),
        .freq_band    (freq_band),
        .seq_done     (seq_done),
        .seq_err      (seq_err),
        .rate_warn    (rate_warn)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_band(input longint r);
        if (r == 0)              return 0;
        if (r < 75_000_000)      return 1;
        if (r < 125_000_000)     return 2;
        if (r < 175_000_000)     return 3;
        return 0;
    endfunction

    function automatic bit exp_warn(input longint r);
        longint c, d;
        case (exp_band(r))
            1: c = 50_000_000;
            2: c = 100_000_000;
            3: c = 150_000_000;
            default: c = 200_000_000;
        endcase
        d = (r > c) ? r - c : c - r;
        return ((r > 50_000_000) && (d > 15_000_000)) || (r > 200_000_000);
    endfunction

    // Power-on run. cal_lat/dll_lat < 0 means the status never arrives.
    task automatic run_on(input int unsigned rate, input int cal_lat, input int dll_lat, input bit poke);
        int pdb_k = -1, en_k = -1, done_k = -1, err_k = -1, fs = -1;
        int e_en, e_done, e_err;
        bit cal_ok;
        @(negedge clk);
        on_req = 1'b1;
        card_rate_hz = rate;
        @(negedge clk);
        on_req = 1'b0;
        chk(pwr_dn_b == 1'b0, "R1 pdb low after on", pwr_dn_b, 0);
        chk(dll_en == 1'b0, "R1 dll_en low after on", dll_en, 0);
        chk(rate_warn == exp_warn(rate), "R3 warn", rate_warn, exp_warn(rate));
        for (int k = 0; k < S + CAL + DLL + 20; k++) begin
            if (k > 0) @(negedge clk);
            if (pdb_k < 0 && pwr_dn_b) pdb_k = k;
            if (en_k < 0 && dll_en) begin en_k = k; fs = freq_band; end
            if (done_k < 0 && seq_done) done_k = k;
            if (err_k < 0 && seq_err) err_k = k;
            if (done_k >= 0 || err_k >= 0) break;
            off_req  = poke && (k == 1 || k == S + 1);
            on_req   = poke && (k == S + 2);
            cal_done = (cal_lat >= 0) && (k >= S + cal_lat);
            dll_ready = (en_k >= 0) && (dll_lat >= 0) && (k >= en_k + dll_lat);
        end
        off_req = 1'b0;
        on_req = 1'b0;
        cal_done = 1'b0;
        dll_ready = 1'b0;
        @(negedge clk);
        chk(!seq_done && !seq_err, "R9 pulse width", {seq_done, seq_err}, 0);
        cal_ok = (cal_lat >= 0) && (cal_lat <= CAL - 1);
        e_en = -1; e_done = -1; e_err = -1;
        if (!cal_ok) begin
            e_err = S + CAL;
        end else begin
            e_en = S + cal_lat + 2;
            if (rate == 0) e_done = e_en;
            else if (dll_lat >= 0 && dll_lat <= DLL - 1) e_done = e_en + dll_lat + 1;
            else e_err = e_en + DLL;
        end
        chk(pdb_k == S, poke ? "R10 ignored request, pdb rise" : "R4 pdb rise cycle", pdb_k, S);
        chk(en_k == e_en, cal_ok ? "R6 dll_en rise cycle" : "R5 dll_en stays low", en_k, e_en);
        if (cal_ok) chk(fs == exp_band(rate), "R2 band", fs, exp_band(rate));
        chk(done_k == e_done, rate == 0 ? "R7 done cycle" : "R8 done cycle", done_k, e_done);
        chk(err_k == e_err, cal_ok ? "R8 err cycle" : "R5 err cycle", err_k, e_err);
    endtask

    task automatic run_off();
        @(negedge clk);
        off_req = 1'b1;
        @(negedge clk);
        off_req = 1'b0;
        chk(!pwr_dn_b && !dll_en, "R1 off drops pdb and dll_en", {pwr_dn_b, dll_en}, 0);
        chk(seq_done && !seq_err, "R1 off done pulse", {seq_done, seq_err}, 2);
        chk(!rate_warn, "R3 warn cleared by off", rate_warn, 0);
        @(negedge clk);
        chk(!seq_done, "R9 off done one cycle", seq_done, 0);
    endtask

    initial begin
        int unsigned rates [14] = '{0, 1, 50_000_000, 64_999_999, 65_000_001, 74_999_999,
                                    75_000_000, 124_999_999, 125_000_000, 174_999_999,
                                    175_000_000, 200_000_000, 200_000_001, 250_000_000};
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({pwr_dn_b, dll_en, freq_band, seq_done, seq_err, rate_warn} == 7'd0,
            "R2 reset state", {pwr_dn_b, dll_en, freq_band, seq_done, seq_err, rate_warn}, 0);

        foreach (rates[i]) run_on(rates[i], i % 5, (i * 7) % 30, 1'b0);
        run_on(100_000_000, 0, 0, 1'b0);
        run_off();
        run_on(65_000_001, CAL - 1, 5, 1'b0);    // R5 last cycle inside window
        run_on(100_000_000, CAL, 5, 1'b0);       // R5 one cycle too late
        run_on(100_000_000, -1, 5, 1'b0);        // R5 never
        run_on(150_000_000, 2, -1, 1'b0);        // R8 lock timeout
        run_on(0, 3, -1, 1'b0);                  // R7 no lock wait
        run_on(120_000_000, 4, 10, 1'b1);        // R10 requests while busy

        // R10: both requests together while idle, power-off wins
        @(negedge clk);
        on_req = 1'b1; off_req = 1'b1; card_rate_hz = 32'd100_000_000;
        @(negedge clk);
        on_req = 1'b0; off_req = 1'b0;
        chk(seq_done, "R10 off wins done", seq_done, 1);
        repeat (S + 2) @(negedge clk);
        chk(!pwr_dn_b, "R10 no power-up after tie", pwr_dn_b, 0);

        for (int n = 0; n < 20; n++) begin
            int unsigned r = $urandom_range(260_000_000, 0);
            int cl = ($urandom_range(9, 0) == 0) ? CAL + 5 : int'($urandom_range(CAL - 1, 0));
            int dl = int'($urandom_range(200, 0));
            if (n % 6 == 0) r = 0;
            run_on(r, cl, dl, 1'b0);
            if (n % 4 == 0) run_off();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200_000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule